// File: doc/BRIEF.md
# FPGA Serial Configuration Loader

This block loads a configuration bitstream into an attached FPGA over a slave-serial link and reports how the attempt ended. After a start request it pulls the active-low program strobe, waits for the target to acknowledge on its INIT pin, releases the strobe and waits for INIT to come back high. It then accepts the image bytes one at a time from a valid/ready byte stream and shifts them out on a data line beside a configuration clock. When every byte has gone out it waits for the target's DONE pin. Each of the three waits has its own timeout, set in system clock cycles, and its own error code.

After a successful load the block gives the freshly configured logic a reset pulse. Program and clock stay high with data low for a set number of cycles, then data rises for the same number of cycles, and the block returns to idle. The INIT and DONE pins pass through two-flop synchronizers before the state machine sees them. Decompression, header parsing and any retry policy belong to the surrounding system.

States: `ST_IDLE` (waiting for start), `ST_PROG` (strobe low, waiting for INIT low), `ST_INIT_HI` (strobe released, waiting for INIT high), `ST_SHIFT` (streaming bytes), `ST_DONE_WAIT` (waiting for DONE), `ST_RST_LO` (target reset, data low), `ST_RST_HI` (target reset, data high). Transitions: `ST_IDLE`→`ST_PROG` on start; `ST_PROG`→`ST_INIT_HI` on INIT low, →`ST_IDLE` on timeout; `ST_INIT_HI`→`ST_SHIFT` on INIT high, →`ST_IDLE` on timeout; `ST_SHIFT`→`ST_DONE_WAIT` when no bytes remain; `ST_DONE_WAIT`→`ST_RST_LO` on DONE high, →`ST_IDLE` on timeout; `ST_RST_LO`→`ST_RST_HI` and `ST_RST_HI`→`ST_IDLE` after `RST_CYC` cycles each.

Top module: `cfg_serial_loader`

## Requirements
- R1: Under reset, and until the first start, the block is idle: `prog_n`=1, `cclk`=0, `busy`=0, `done`=0, `err_code`=0, `in_ready`=0.
- R2: A start in idle latches `total_len`, drives `prog_n` low and raises `busy`; if INIT is not seen low within `T_INIT_LO` cycles of entering this phase, the block returns to idle with `prog_n` high, `done`=1 and `err_code`=1.
- R3: Once INIT is seen low, `prog_n` is released; if INIT is not seen high within `T_INIT_HI` cycles of entering this phase, the block returns to idle with `done`=1 and `err_code`=2.
- R4: Exactly `total_len` bytes are shifted out, each MSB first, one bit per rising edge of `cclk`; `dout` changes only while `cclk` is low; a length of zero skips shifting.
- R5: `in_ready` is high only in the shift phase while bytes remain; in idle and in every wait phase no byte is taken, whatever `in_valid` does.
- R6: After the last byte the block waits for DONE; if DONE is not seen high within `T_DONE` cycles, it returns to idle with `done`=1 and `err_code`=3.
- R7: When DONE is seen high, the block holds `prog_n`=1, `cclk`=1, `dout`=0 for `RST_CYC` cycles, then `dout`=1 for `RST_CYC` cycles, then returns to idle with `done`=1 and `err_code`=0.
- R8: A run that ends in a timeout produces no target reset pulse.
- R9: A start while `busy` is high is ignored: the strobe is not pulsed again and the running load completes unchanged.
- R10: `done` and `err_code` hold their values in idle until the next accepted start, which clears `done`; a nonzero `err_code` is only ever shown with `done` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (taken only in idle) |
| total_len | input | LEN_W | Number of image bytes for this load |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| tgt_init | input | 1 | Target INIT status pin |
| tgt_done | input | 1 | Target DONE status pin |
| prog_n | output | 1 | Active-low program strobe to target |
| cclk | output | 1 | Configuration clock to target |
| dout | output | 1 | Configuration data to target |
| busy | output | 1 | A load is in progress |
| done | output | 1 | The last load has ended |
| err_code | output | 2 | 0 ok, 1 INIT not low, 2 INIT not high, 3 DONE not high |

## Verification
On every cycle the assertions check that the strobe only falls straight after a start taken in idle, that `in_ready` never rises outside the shift phase with bytes left, that `dout` holds steady across each high phase of `cclk`, that a saturated timer stays saturated, and that the result outputs hold in idle. Only the bench scenarios, driven against a behavioural target that can be told to withhold INIT low, INIT high or DONE, can show which error code each failure produces, that the received bits match the fed bytes in MSB-first order, that the reset pulse has exactly the right length and appears only after success, and that a second start mid-load is dropped.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_INIT_HI,
        ST_SHIFT,
        ST_DONE_WAIT,
        ST_RST_LO,
        ST_RST_HI
    } ld_state_t;

    typedef enum logic [1:0] {
        LD_OK          = 2'd0,
        LD_NO_INIT_LO  = 2'd1,
        LD_NO_INIT_HI  = 2'd2,
        LD_NO_DONE     = 2'd3
    } ld_err_t;

endpackage

// File: rtl/loader_timer.sv
module loader_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == limit);

    AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart) |=> expired);  // R2
endmodule

// File: rtl/loader_shifter.sv
module loader_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          can_take,
    input  logic          in_valid,
    input  logic [BW-1:0] in_data,
    output logic          in_ready,
    output logic          clk_out,
    output logic          bit_out,
    output logic          byte_done
);
    localparam int BCW = (BW > 1) ? $clog2(BW) : 1;
    localparam logic [BCW-1:0] LAST = BCW'(BW - 1);

    logic [BW-1:0]  sh;
    logic [BCW-1:0] bcnt;
    logic           ph;
    logic           full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            bcnt <= '0;
            ph   <= 1'b0;
            full <= 1'b0;
        end else if (!en) begin
            bcnt <= '0;
            ph   <= 1'b0;
            full <= 1'b0;
        end else if (!full) begin
            if (in_valid && can_take) begin
                sh   <= in_data;
                bcnt <= '0;
                ph   <= 1'b0;
                full <= 1'b1;
            end
        end else if (!ph) begin
            ph <= 1'b1;
        end else begin
            ph <= 1'b0;
            if (bcnt == LAST) begin
                full <= 1'b0;
            end else begin
                bcnt <= bcnt + 1'b1;
                sh   <= {sh[BW-2:0], 1'b0};
            end
        end
    end

    assign in_ready  = en && can_take && !full;
    assign clk_out   = full && ph;
    assign bit_out   = full && sh[BW-1];
    assign byte_done = en && full && ph && (bcnt == LAST);

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clk_out) |-> $stable(bit_out));  // R4
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int T_INIT_LO = 1000,
    parameter int T_INIT_HI = 1000,
    parameter int T_DONE    = 10000,
    parameter int RST_CYC   = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             tgt_init,
    input  logic             tgt_done,
    output logic             prog_n,
    output logic             cclk,
    output logic             dout,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err_code
);
    localparam int M1   = (T_INIT_LO > T_INIT_HI) ? T_INIT_LO : T_INIT_HI;
    localparam int M2   = (M1 > T_DONE) ? M1 : T_DONE;
    localparam int TMAX = (M2 > RST_CYC) ? M2 : RST_CYC;
    localparam int CW   = $clog2(TMAX + 1);

    ld_state_t        state, state_n;
    logic [LEN_W-1:0] rem;
    logic [1:0]       init_q, done_q;
    logic             init_s, done_s;
    logic [CW-1:0]    limit;
    logic             expired;
    logic             fin_set;
    ld_err_t          fin_code;
    logic             sh_clk, sh_bit, byte_done;
    logic             in_shift;

    // Status pin synchronizers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= 2'b11;
            done_q <= 2'b00;
        end else begin
            init_q <= {init_q[0], tgt_init};
            done_q <= {done_q[0], tgt_done};
        end
    end
    assign init_s = init_q[1];
    assign done_s = done_q[1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Next state and completion code
    always_comb begin
        state_n  = state;
        fin_set  = 1'b0;
        fin_code = LD_OK;
        unique case (state)
            ST_IDLE:      if (start) state_n = ST_PROG;
            ST_PROG: begin
                if (!init_s) state_n = ST_INIT_HI;
                else if (expired) begin
                    state_n = ST_IDLE; fin_set = 1'b1; fin_code = LD_NO_INIT_LO;
                end
            end
            ST_INIT_HI: begin
                if (init_s) state_n = ST_SHIFT;
                else if (expired) begin
                    state_n = ST_IDLE; fin_set = 1'b1; fin_code = LD_NO_INIT_HI;
                end
            end
            ST_SHIFT:     if (rem == '0) state_n = ST_DONE_WAIT;
            ST_DONE_WAIT: begin
                if (done_s) state_n = ST_RST_LO;
                else if (expired) begin
                    state_n = ST_IDLE; fin_set = 1'b1; fin_code = LD_NO_DONE;
                end
            end
            ST_RST_LO:    if (expired) state_n = ST_RST_HI;
            ST_RST_HI: begin
                if (expired) begin
                    state_n = ST_IDLE; fin_set = 1'b1; fin_code = LD_OK;
                end
            end
            default:      state_n = ST_IDLE;
        endcase
    end

    // Timeout limit per phase
    always_comb begin
        unique case (state)
            ST_INIT_HI:           limit = CW'(T_INIT_HI);
            ST_DONE_WAIT:         limit = CW'(T_DONE);
            ST_RST_LO, ST_RST_HI: limit = CW'(RST_CYC - 1);
            default:              limit = CW'(T_INIT_LO);
        endcase
    end

    loader_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_n != state),
        .limit   (limit),
        .expired (expired)
    );

    assign in_shift = (state == ST_SHIFT);

    loader_shifter #(.BW(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (in_shift),
        .can_take  (rem != '0),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .clk_out   (sh_clk),
        .bit_out   (sh_bit),
        .byte_done (byte_done)
    );

    // Byte count and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem      <= '0;
            done     <= 1'b0;
            err_code <= 2'd0;
        end else if (state == ST_IDLE && start) begin
            rem      <= total_len;
            done     <= 1'b0;
            err_code <= 2'd0;
        end else begin
            if (in_shift && byte_done) rem <= rem - 1'b1;
            if (fin_set) begin
                done     <= 1'b1;
                err_code <= fin_code;
            end
        end
    end

    // Pin outputs
    always_comb begin
        prog_n = 1'b1;
        cclk   = 1'b0;
        dout   = 1'b0;
        unique case (state)
            ST_PROG:   prog_n = 1'b0;
            ST_SHIFT:  begin cclk = sh_clk; dout = sh_bit; end
            ST_RST_LO: cclk = 1'b1;
            ST_RST_HI: begin cclk = 1'b1; dout = 1'b1; end
            default:   ;
        endcase
    end
    assign busy = (state != ST_IDLE);

    AST_STROBE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> ($past(state) == ST_IDLE && $past(start)));  // R9
    AST_READY_ONLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (state == ST_SHIFT && rem != '0));  // R5
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(err_code) && $stable(done)));  // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> done);  // R10
endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
    localparam int LW = 8, TI = 40, TH = 40, TD = 60, RC = 20;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [LW-1:0] total_len = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic tgt_init = 1'b1, tgt_done = 1'b0;
    logic in_ready, prog_n, cclk, dout, busy, done;
    logic [1:0] err_code;

    always #5 clk = ~clk;

    cfg_serial_loader #(.LEN_W(LW), .T_INIT_LO(TI), .T_INIT_HI(TH),
                        .T_DONE(TD), .RST_CYC(RC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tgt_init(tgt_init), .tgt_done(tgt_done), .prog_n(prog_n),
        .cclk(cclk), .dout(dout), .busy(busy), .done(done), .err_code(err_code));

    int n_chk = 0, n_bad = 0;
    bit lo_en = 1, hi_en = 1, dn_en = 1;
    int exp_bits = 0, nbits = 0;
    logic [7:0] cur = '0;
    logic [7:0] rx_mem [16];
    logic cclk_prev = 1'b0, prog_prev = 1'b1;
    int rst_a = 0, rst_b = 0, rdy_cnt = 0, prog_falls = 0;
    bit feed_on = 0, idle_valid = 0, xfer_pend = 0;
    int flen = 0, fidx = 0;

    function automatic logic [7:0] pat(int i);
        return 8'h5A ^ 8'(i * 29);
    endfunction

    // {len[7:0], init_lo_en, init_hi_en, done_en, exp_err[1:0]}
    localparam logic [12:0] VEC [7] = '{
        {8'd3, 1'b1, 1'b1, 1'b1, 2'd0},   // R7 success
        {8'd1, 1'b1, 1'b1, 1'b1, 2'd0},   // R4 single byte
        {8'd0, 1'b1, 1'b1, 1'b1, 2'd0},   // R4 zero length
        {8'd2, 1'b0, 1'b1, 1'b1, 2'd1},   // R2 INIT never low
        {8'd2, 1'b1, 1'b0, 1'b1, 2'd2},   // R3 INIT never high
        {8'd4, 1'b1, 1'b1, 1'b0, 2'd3},   // R6 DONE never high
        {8'd5, 1'b1, 1'b1, 1'b1, 2'd0}    // R7 longer image
    };

    // Target model, monitor and stream feeder, all away from the active edge
    always @(negedge clk) begin
        if (busy && prog_n && cclk && tgt_done) begin
            if (dout) rst_b++; else rst_a++;
        end
        if (in_ready) rdy_cnt++;
        if (prog_prev && !prog_n) prog_falls++;
        if (!prog_n) begin
            tgt_done = 1'b0;
            nbits = 0;
            if (lo_en) tgt_init = 1'b0;
        end else begin
            if (!tgt_init && hi_en) tgt_init = 1'b1;
            if (cclk && !cclk_prev && tgt_init && !tgt_done) begin
                cur = {cur[6:0], dout};
                if (nbits % 8 == 7 && nbits / 8 < 16) rx_mem[nbits / 8] = cur;
                nbits++;
            end
            if (dn_en && tgt_init && !tgt_done && nbits == exp_bits) tgt_done = 1'b1;
        end
        prog_prev = prog_n;
        cclk_prev = cclk;
        if (xfer_pend) fidx++;
        in_valid  = (feed_on && fidx < flen) || idle_valid;
        in_data   = pat(fidx);
        xfer_pend = feed_on && (fidx < flen) && in_ready;
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(int len, bit lo, bit hi, bit dn, int exp_err,
                       string tag, bit second_start);
        int guard, bad_bytes;
        @(negedge clk);
        lo_en = lo; hi_en = hi; dn_en = dn; exp_bits = len * 8;
        for (int i = 0; i < 16; i++) rx_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_a = 0; rst_b = 0; rdy_cnt = 0; prog_falls = 0;
        fidx = 0; flen = len; feed_on = 1;
        total_len = LW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", {tag, " done cleared by start"}, int'(done), 0);
        chk("R2", {tag, " busy after start"}, int'(busy), 1);
        if (second_start) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        feed_on = 0;
        chk(tag, "busy at end", int'(busy), 0);
        chk(tag, "done at end", int'(done), 1);
        chk(tag, "err_code", int'(err_code), exp_err);
        chk("R9", {tag, " strobe pulses"}, prog_falls, 1);
        if (exp_err == 0 || exp_err == 3) begin
            chk("R4", {tag, " bits received"}, nbits, len * 8);
            bad_bytes = 0;
            for (int i = 0; i < len; i++) if (rx_mem[i] != pat(i)) bad_bytes++;
            chk("R4", {tag, " bytes MSB first"}, bad_bytes, 0);
            chk("R5", {tag, " ready cycles"}, rdy_cnt, len);
        end else begin
            chk("R4", {tag, " no bits on failure"}, nbits, 0);
            chk("R5", {tag, " no ready in wait phase"}, rdy_cnt, 0);
        end
        if (exp_err == 0) begin
            chk("R7", {tag, " reset data-low cycles"}, rst_a, RC);
            chk("R7", {tag, " reset data-high cycles"}, rst_b, RC);
        end else begin
            chk("R8", {tag, " no reset pulse"}, rst_a + rst_b, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "prog_n in reset", int'(prog_n), 1);
        chk("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "prog_n idle", int'(prog_n), 1);
        chk("R1", "cclk idle", int'(cclk), 0);
        chk("R1", "done idle", int'(done), 0);
        chk("R1", "err idle", int'(err_code), 0);
        chk("R1", "ready idle", int'(in_ready), 0);

        for (int v = 0; v < 7; v++) begin
            run(int'(VEC[v][12:5]), VEC[v][4], VEC[v][3], VEC[v][2],
                int'(VEC[v][1:0]), $sformatf("vec%0d", v), 1'b0);
        end

        // R10: result holds in idle after a failure
        run(2, 1'b1, 1'b1, 1'b0, 3, "R6 hold", 1'b0);
        repeat (30) @(negedge clk);
        chk("R10", "done held", int'(done), 1);
        chk("R10", "err held", int'(err_code), 3);

        // R5: valid offered in idle is not taken
        rdy_cnt = 0;
        idle_valid = 1;
        repeat (10) @(negedge clk);
        idle_valid = 0;
        chk("R5", "ready with valid in idle", rdy_cnt, 0);
        chk("R5", "nothing shifted in idle", int'(cclk), 0);

        // R9: second start during a load is dropped
        run(3, 1'b1, 1'b1, 1'b1, 0, "R9 restart", 1'b1);

        // R3 then recovery: stuck INIT followed by a clean load
        run(1, 1'b1, 1'b0, 1'b1, 2, "R3 stuck", 1'b0);
        run(2, 1'b1, 1'b1, 1'b1, 0, "R7 recover", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule